// File: doc/BRIEF.md
# Phase/Frequency Detector with Mode Control

This block compares two single-cycle strobe streams in the system clock domain: one from the divided reference and one from the divided VCO feedback. It works as a three-state phase/frequency detector. The strobe that arrives first raises its pump request, and that request stays high until the other strobe arrives. Once both requests are high, both clear in the next cycle. Because of this, a loop in lock shows only one-cycle overlapping pulses on both requests.

Mode inputs adjust how the detector is used:
- A polarity bit swaps the up and down requests for a VCO with a negative tuning slope.
- A disable bit turns off the pump enable.
- A two-bit selector picks what the lock output shows. The choices are a forced low level, the local lock indication, the local lock combined with a peer loop's lock, or fast-acquisition mode.
- In fast-acquisition mode with the current-magnitude bit high, an active-low drive output is asserted and the high-current select is forced. This mode is released only when the pump is idle.
- A powerdown request takes effect only once the pump is idle. While it is in effect, strobes are ignored and the lock history is cleared.

Top module: `pfd_mode_top`

## Requirements
- R1: A strobe arriving while the detector is idle raises its own request in the next cycle. The request stays high until the opposite strobe has been captured. The cycle after both requests are high, both are low again unless new strobes were captured in that cycle. Simultaneous strobes give a single cycle with both requests high.
- R2: With `polarity`=1, the reference request appears on `pumpUp` and the feedback request on `pumpDn`. With `polarity`=0, the two are swapped.
- R3: While `triMode` is 1, `pumpEn` is 0 in the same cycle. When `triMode` returns to 0, `pumpEn` is 1 again.
- R4: A comparison's error is the number of cycles in which exactly one request was high. Lock is declared after LOCK_COUNT consecutive comparisons with error ≤ ERR_THRESH, and becomes visible the cycle after the last comparison clears. A single comparison with a larger error drops lock at that same point.
- R5: The `ldMode` encoding is as follows. 2'b00 drives `lockDet` low. 2'b01 shows the local lock, pulled low in any cycle where exactly one request is high. 2'b10 shows the same value ANDed with `peerLock`. 2'b11 (fast-acquisition mode) drives `lockDet` low.
- R6: With `ldMode`=2'b11 and `curMag`=1, `fastlockN` is 0 from the next cycle, and `curSel` is 1 while fast acquisition is active.
- R7: When the fast-acquisition request is removed while a pump request is high, `fastlockN` stays 0 and `curSel` stays 1 until the first idle cycle. Both return to 1 and `curMag` respectively on the cycle after that idle cycle.
- R8: When `pdReq` is raised during an active pump request, `pumpEn` stays 1 until the pump is idle and drops the cycle after. While powered down, strobes are ignored and the lock history is cleared. Dropping `pdReq` restores `pumpEn` on the next cycle.
- R9: After reset, both pump requests are 0, `pumpEn` is 1, `lockDet` is 0, `fastlockN` is 1 and `curSel` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| refPulse | input | 1 | One-cycle strobe from the divided reference |
| fbPulse | input | 1 | One-cycle strobe from the divided feedback |
| polarity | input | 1 | 1 = positive VCO slope, 0 = swap up/down |
| triMode | input | 1 | 1 = disable the pump output |
| pdReq | input | 1 | Powerdown request, applied when the pump is idle |
| curMag | input | 1 | High pump-current select |
| ldMode | input | 2 | Lock/fast-acquisition output selector |
| peerLock | input | 1 | Lock indication of the other loop |
| pumpUp | output | 1 | Pump-up request |
| pumpDn | output | 1 | Pump-down request |
| pumpEn | output | 1 | Pump drive enable (0 = high impedance) |
| curSel | output | 1 | High-current select to the pump |
| lockDet | output | 1 | Lock detect output |
| fastlockN | output | 1 | Active-low fast-acquisition drive |

## Verification
The bench builds the block with LOCK_COUNT=3 and ERR_THRESH=2. With these values, a lock can be gained in three comparisons and then lost through one comparison with a three-cycle error. Within one short run, this covers both the error that is just accepted (two cycles) and the first error that is rejected. The same run also exercises the idle-point gating of fast-acquisition exit and of powerdown entry. In both cases a three-cycle pump pulse is used, so the delayed transition falls several cycles after the request changes.

// File: rtl/pfd_mode_pkg.sv
package pfd_mode_pkg;
  typedef enum logic [1:0] {
    LD_OFF  = 2'b00,
    LD_OWN  = 2'b01,
    LD_BOTH = 2'b10,
    LD_FAST = 2'b11
  } ldSel_e;

  typedef struct packed {
    logic holdClear;
  } dpCtrl_t;

  typedef struct packed {
    logic upReq;
    logic dnReq;
    logic locked;
    logic idle;
  } dpStat_t;
endpackage

// File: rtl/pfd_datapath.sv
module pfd_datapath
  import pfd_mode_pkg::*;
#(
  parameter int LOCK_COUNT = 4,
  parameter int ERR_THRESH = 1,
  parameter int ERR_W      = 8
) (
  input  logic    clk,
  input  logic    rstN,
  input  logic    refPulse,
  input  logic    fbPulse,
  input  dpCtrl_t ctrl,
  output dpStat_t stat
);
  localparam int GOOD_W = $clog2(LOCK_COUNT + 1);
  localparam logic [GOOD_W-1:0] GOOD_MAX = GOOD_W'(LOCK_COUNT);
  localparam logic [ERR_W-1:0] ERR_LIM = ERR_W'(ERR_THRESH);
  localparam logic [ERR_W-1:0] ERR_MAX = {ERR_W{1'b1}};

  logic upQ, dnQ;
  logic [ERR_W-1:0] errCnt;
  logic [GOOD_W-1:0] goodCnt;

  always_ff @(posedge clk) begin
    if (!rstN || ctrl.holdClear) begin
      upQ     <= 1'b0;
      dnQ     <= 1'b0;
      errCnt  <= '0;
      goodCnt <= '0;
    end else if (upQ && dnQ) begin
      upQ    <= refPulse;
      dnQ    <= fbPulse;
      errCnt <= '0;
      if (errCnt <= ERR_LIM) begin
        if (goodCnt != GOOD_MAX) goodCnt <= goodCnt + GOOD_W'(1);
      end else begin
        goodCnt <= '0;
      end
    end else begin
      upQ <= upQ | refPulse;
      dnQ <= dnQ | fbPulse;
      if ((upQ ^ dnQ) && errCnt != ERR_MAX) errCnt <= errCnt + ERR_W'(1);
    end
  end

  assign stat.upReq  = upQ;
  assign stat.dnReq  = dnQ;
  assign stat.locked = (goodCnt == GOOD_MAX);
  assign stat.idle   = !upQ && !dnQ;

  // R1
  reset_overlap_chk: assert property (@(posedge clk) disable iff (!rstN)
    (upQ && dnQ && !refPulse && !fbPulse && !ctrl.holdClear) |=> (!upQ && !dnQ));

  // R4
  lock_rise_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(stat.locked) |-> $past(upQ && dnQ));
endmodule

// File: rtl/pfd_control.sv
module pfd_control
  import pfd_mode_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  dpStat_t    stat,
  input  logic       polarity,
  input  logic       triMode,
  input  logic       pdReq,
  input  logic       curMag,
  input  logic [1:0] ldMode,
  input  logic       peerLock,
  output dpCtrl_t    ctrl,
  output logic       pumpUp,
  output logic       pumpDn,
  output logic       pumpEn,
  output logic       curSel,
  output logic       lockDet,
  output logic       fastlockN
);
  logic pwrDn, fastActive, fastReq, quietLock;

  assign fastReq = curMag && (ldMode == LD_FAST);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      pwrDn      <= 1'b0;
      fastActive <= 1'b0;
    end else begin
      pwrDn      <= pdReq && (pwrDn || stat.idle);
      fastActive <= fastReq || (fastActive && !stat.idle);
    end
  end

  assign ctrl.holdClear = pwrDn;

  assign pumpUp    = polarity ? stat.upReq : stat.dnReq;
  assign pumpDn    = polarity ? stat.dnReq : stat.upReq;
  assign pumpEn    = !triMode && !pwrDn;
  assign curSel    = curMag || fastActive;
  assign fastlockN = !fastActive;
  assign quietLock = stat.locked && !(stat.upReq ^ stat.dnReq);

  always_comb begin
    unique case (ldMode)
      LD_OWN:  lockDet = quietLock;
      LD_BOTH: lockDet = quietLock && peerLock;
      default: lockDet = 1'b0;
    endcase
  end

  // R8
  pd_entry_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(pwrDn) |-> $past(stat.idle));

  // R8
  pd_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    (pwrDn && $past(pwrDn)) |-> (!stat.upReq && !stat.dnReq));

  // R7
  fast_exit_chk: assert property (@(posedge clk) disable iff (!rstN)
    $fell(fastActive) |-> $past(stat.idle));

  // R3
  tri_en_chk: assert property (@(posedge clk) disable iff (!rstN)
    triMode |-> !pumpEn);
endmodule

// File: rtl/pfd_mode_top.sv
module pfd_mode_top
  import pfd_mode_pkg::*;
#(
  parameter int LOCK_COUNT = 4,
  parameter int ERR_THRESH = 1,
  parameter int ERR_W      = 8
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       refPulse,
  input  logic       fbPulse,
  input  logic       polarity,
  input  logic       triMode,
  input  logic       pdReq,
  input  logic       curMag,
  input  logic [1:0] ldMode,
  input  logic       peerLock,
  output logic       pumpUp,
  output logic       pumpDn,
  output logic       pumpEn,
  output logic       curSel,
  output logic       lockDet,
  output logic       fastlockN
);
  dpCtrl_t ctrl;
  dpStat_t stat;

  pfd_datapath #(
    .LOCK_COUNT(LOCK_COUNT),
    .ERR_THRESH(ERR_THRESH),
    .ERR_W(ERR_W)
  ) u_dp (
    .clk(clk), .rstN(rstN), .refPulse(refPulse), .fbPulse(fbPulse),
    .ctrl(ctrl), .stat(stat)
  );

  pfd_control u_ctl (
    .clk(clk), .rstN(rstN), .stat(stat), .polarity(polarity),
    .triMode(triMode), .pdReq(pdReq), .curMag(curMag), .ldMode(ldMode),
    .peerLock(peerLock), .ctrl(ctrl), .pumpUp(pumpUp), .pumpDn(pumpDn),
    .pumpEn(pumpEn), .curSel(curSel), .lockDet(lockDet), .fastlockN(fastlockN)
  );
endmodule

// File: tb/pfd_mode_top_test.sv
module pfd_mode_top_test;
  localparam int LC = 3;
  localparam int TH = 2;
  localparam int S_UP = 0, S_DN = 1, S_EN = 2, S_LD = 3, S_FL = 4, S_CS = 5;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic refPulse = 1'b0, fbPulse = 1'b0;
  logic polarity = 1'b1, triMode = 1'b0, pdReq = 1'b0, curMag = 1'b0;
  logic [1:0] ldMode = 2'b01;
  logic peerLock = 1'b0;
  logic pumpUp, pumpDn, pumpEn, curSel, lockDet, fastlockN;

  always #2.5 clk = ~clk;

  pfd_mode_top #(.LOCK_COUNT(LC), .ERR_THRESH(TH), .ERR_W(8)) uut (
    .clk(clk), .rstN(rstN), .refPulse(refPulse), .fbPulse(fbPulse),
    .polarity(polarity), .triMode(triMode), .pdReq(pdReq), .curMag(curMag),
    .ldMode(ldMode), .peerLock(peerLock), .pumpUp(pumpUp), .pumpDn(pumpDn),
    .pumpEn(pumpEn), .curSel(curSel), .lockDet(lockDet), .fastlockN(fastlockN)
  );

  typedef struct {
    int    atCyc;
    int    sig;
    logic  val;
    string req;
  } item_t;

  item_t q[$];
  int cyc = 0;
  int nChecks = 0;
  int nFail = 0;
  int gc = 0;
  bit done = 0;

  always @(posedge clk) cyc <= cyc + 1;

  function automatic logic sigVal(int s);
    case (s)
      S_UP: return pumpUp;
      S_DN: return pumpDn;
      S_EN: return pumpEn;
      S_LD: return lockDet;
      S_FL: return fastlockN;
      default: return curSel;
    endcase
  endfunction

  function automatic void pushExp(int at, int s, logic v, string r);
    item_t it;
    int i;
    it.atCyc = at; it.sig = s; it.val = v; it.req = r;
    i = q.size();
    while (i > 0 && q[i-1].atCyc > at) i--;
    q.insert(i, it);
  endfunction

  // scoreboard monitor
  always @(negedge clk) begin
    while (q.size() > 0 && q[0].atCyc <= cyc) begin
      item_t it;
      logic got;
      it = q.pop_front();
      got = sigVal(it.sig);
      nChecks++;
      if (got !== it.val) begin
        nFail++;
        $display("FAIL %s cyc=%0d sig=%0d actual=%b expected=%b", it.req, cyc, it.sig, got, it.val);
      end
    end
  end

  function automatic logic expLock(logic l, logic inBetween);
    logic v;
    v = l && !inBetween;
    case (ldMode)
      2'b01: return v;
      2'b10: return v && peerLock;
      default: return 1'b0;
    endcase
  endfunction

  task automatic idle(int n);
    for (int i = 0; i < n; i++) @(posedge clk);
    #1;
  endtask

  // one comparison: lead strobe at j=0, lag strobe at j=k
  task automatic runComp(int k, bit refLead, bit chkLock, int dropMagAt, int pdAt);
    int base;
    logic oldL, newL, upI, dnI;
    base = cyc + 1;
    oldL = (gc == LC);
    for (int j = 1; j <= k + 2; j++) begin
      logic leadV, lagV;
      leadV = (j <= k + 1);
      lagV  = (j == k + 1);
      upI = refLead ? leadV : lagV;
      dnI = refLead ? lagV : leadV;
      pushExp(base + j, S_UP, polarity ? upI : dnI, polarity ? "R1" : "R2");
      pushExp(base + j, S_DN, polarity ? dnI : upI, polarity ? "R1" : "R2");
      if (chkLock && j <= k) pushExp(base + j, S_LD, expLock(oldL, 1'b1), "R5");
      if (chkLock && j == k + 1) pushExp(base + j, S_LD, expLock(oldL, 1'b0), "R5");
    end
    if (chkLock) begin
      if (k <= TH) gc = (gc < LC) ? gc + 1 : LC; else gc = 0;
      newL = (gc == LC);
      pushExp(base + k + 2, S_LD, expLock(newL, 1'b0), "R4");
    end
    for (int j = 0; j <= k + 1; j++) begin
      logic leadS, lagS;
      @(posedge clk); #1;
      leadS = (j == 0);
      lagS  = (j == k);
      refPulse = refLead ? leadS : lagS;
      fbPulse  = refLead ? lagS : leadS;
      if (j == dropMagAt) curMag = 1'b0;
      if (j == pdAt) pdReq = 1'b1;
    end
    refPulse = 1'b0; fbPulse = 1'b0;
  endtask

  initial begin
    int base;
    idle(3);
    rstN = 1'b1;
    // R9 reset state
    base = cyc;
    pushExp(base + 1, S_UP, 1'b0, "R9");
    pushExp(base + 1, S_DN, 1'b0, "R9");
    pushExp(base + 1, S_EN, 1'b1, "R9");
    pushExp(base + 1, S_LD, 1'b0, "R9");
    pushExp(base + 1, S_FL, 1'b1, "R9");
    pushExp(base + 1, S_CS, 1'b0, "R9");
    idle(2);

    // R1 simultaneous, R4 build lock with errors 0, 2 (limit) and 1
    runComp(0, 1, 1, -1, -1); idle(2);
    runComp(2, 1, 1, -1, -1); idle(2);
    runComp(1, 0, 1, -1, -1); idle(2);
    // R5 masking while one request is high
    runComp(1, 1, 1, -1, -1); idle(2);
    // R5 combined mode and off mode
    ldMode = 2'b10; peerLock = 1'b0;
    runComp(0, 1, 1, -1, -1); idle(2);
    peerLock = 1'b1;
    runComp(0, 1, 1, -1, -1); idle(2);
    ldMode = 2'b00;
    runComp(0, 1, 1, -1, -1); idle(2);
    ldMode = 2'b01;
    // R4 error above threshold drops lock
    runComp(3, 1, 1, -1, -1); idle(2);
    // R2 inverted polarity
    polarity = 1'b0;
    runComp(2, 1, 1, -1, -1); idle(2);
    runComp(1, 0, 1, -1, -1); idle(2);
    polarity = 1'b1;

    // R3 pump disable
    triMode = 1'b1;
    pushExp(cyc, S_EN, 1'b0, "R3");
    idle(2);
    triMode = 1'b0;
    pushExp(cyc, S_EN, 1'b1, "R3");
    idle(2);

    // R6 fast-acquisition entry
    ldMode = 2'b11; curMag = 1'b1;
    base = cyc;
    pushExp(base + 1, S_FL, 1'b0, "R6");
    pushExp(base + 1, S_CS, 1'b1, "R6");
    pushExp(base + 1, S_LD, 1'b0, "R5");
    idle(2);
    // R7 exit waits for idle: k=3, magnitude dropped at j=1
    base = cyc + 1;
    pushExp(base + 2, S_FL, 1'b0, "R7");
    pushExp(base + 4, S_CS, 1'b1, "R7");
    pushExp(base + 5, S_FL, 1'b0, "R7");
    pushExp(base + 6, S_FL, 1'b1, "R7");
    pushExp(base + 6, S_CS, 1'b0, "R7");
    runComp(3, 1, 1, 1, -1); idle(3);
    ldMode = 2'b01;

    // R8 powerdown raised mid-pulse
    base = cyc + 1;
    pushExp(base + 3, S_EN, 1'b1, "R8");
    pushExp(base + 5, S_EN, 1'b1, "R8");
    pushExp(base + 6, S_EN, 1'b0, "R8");
    runComp(3, 1, 0, -1, 1); idle(3);
    gc = 0;
    // strobes ignored while powered down
    base = cyc + 1;
    pushExp(base + 1, S_UP, 1'b0, "R8");
    pushExp(base + 1, S_DN, 1'b0, "R8");
    pushExp(base + 2, S_UP, 1'b0, "R8");
    @(posedge clk); #1; refPulse = 1'b1;
    @(posedge clk); #1; refPulse = 1'b0;
    idle(2);
    pdReq = 1'b0;
    pushExp(cyc + 1, S_EN, 1'b1, "R8");
    pushExp(cyc + 1, S_LD, 1'b0, "R8");
    idle(3);
    // normal compare after release
    runComp(0, 1, 1, -1, -1); idle(3);

    while (q.size() > 0) @(negedge clk);
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFail);
    $finish;
  end

  initial begin
    #50000;
    if (!done) begin
      nFail++;
      nChecks++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFail);
      $finish;
    end
  end
endmodule